// File: doc/BRIEF.md
# Indexed Event Statistics Counter Bank

This block holds a bank of event counters that software reaches through a small synchronous register bus. It does not map each counter to its own address. Software first writes a counter index into a selector register. After that, one control window and one count window act on the selected counter only. Each counter watches one chosen input from a vector of event sources, which are assumed synchronous to the block clock. A counter runs in one of four modes. Two modes count clock cycles, either while the source is high or while it is low. The other two count rising edges or falling edges, found by comparing the source with its value one cycle earlier.

A counter stops at all ones and stays there until software writes its count. All ones is the overflow marker. A read-only capability word reports the bank size. One interrupt line rises when any counter that has its interrupt enable set sits at all ones, provided the interrupt mask bit is set. Clearing the count or the mask bit drops the line again.

Top module: `evstat_bank`

## Requirements
- R1: Offset 0 (selector) stores the low log2(NUM_TIMERS) bits of the written data, 3 bits by default, and reads them back. Writes and reads at offsets 1 and 2 reach only the counter named by the selector.
- R2: The control word at offset 1 has this layout: bit 0 enable, bit 1 interrupt enable, bits 3:2 mode, and the source number from bit 8 upward, 3 bits wide by default. It reads back in the same layout, with all other bits zero.
- R3: The mode codes are 0 for cycles with the source high and 1 for cycles with it low. Code 2 counts rising edges (source 1, previous cycle 0) and code 3 counts falling edges (source 0, previous cycle 1). A qualifying cycle is visible in the count read after the next clock edge.
- R4: A count at all ones (0xFFFFFFFF by default) does not wrap. It holds that value until offset 2 is written.
- R5: A write to offset 2 loads the written value into the selected count, so writing zero clears it. The write takes priority over an event in the same cycle.
- R6: With enable at 0 the count holds its value. Setting enable again resumes counting from that value.
- R7: Offset 3 is read-only. It returns NUM_TIMERS-1 in bits 7:0 and NUM_SRC-1 in bits 15:8, which is 0x0707 by default.
- R8: Bit 0 of offset 4 is the interrupt mask. The irq output is registered. It is 1 one cycle after a state in which the mask is 1 and some counter with interrupt enable set is at all ones, and 0 otherwise. Offset 5 bit 0 reads irq.
- R9: After reset the selector is 0, the mask is 0 and all counts are 0. Counter i has enable 1, interrupt enable 0, mode i mod 4 and source i mod NUM_SRC.
- R10: Offsets 6 and 7 read zero. Writes to offsets 3, 5, 6 and 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, read when 0 |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current offset, combinational |
| src_in | input | NUM_SRC | Event source vector, synchronous to clk |
| irq | output | 1 | Masked overflow interrupt |

## Verification
Read data is combinational, so it shows the state left by the most recent clock edge. Count updates and register writes take effect at the edge that samples them. The irq output lags its condition by one more edge. The bench drives all inputs on the falling clock edge and advances a behavioural model at each rising edge. It compares the outputs 1 ns after that rising edge, when both the model and the design hold their post-edge state. Directed sequences then check exact counts at hand-computed points: edge counts after pulse trains, the freeze window of a disabled counter, and irq rising two edges after the mask write.

// File: rtl/evstat_pkg.sv
package evstat_pkg;

    localparam int DATA_W        = 32;
    localparam int ADDR_W        = 3;
    localparam int SRC_FW        = 8;
    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_IE_BIT   = 1;
    localparam int CTRL_MODE_LSB = 2;
    localparam int CTRL_SRC_LSB  = 8;

    typedef enum logic [ADDR_W-1:0] {
        REG_SEL   = 3'd0,
        REG_CTRL  = 3'd1,
        REG_COUNT = 3'd2,
        REG_CAP   = 3'd3,
        REG_IMASK = 3'd4,
        REG_ISTAT = 3'd5
    } reg_off_e;

    typedef enum logic [1:0] {
        MODE_HIGH = 2'd0,
        MODE_LOW  = 2'd1,
        MODE_RISE = 2'd2,
        MODE_FALL = 2'd3
    } cnt_mode_e;

    typedef struct packed {
        logic [SRC_FW-1:0] src;
        cnt_mode_e         mode;
        logic              int_en;
        logic              en;
    } tmr_cfg_t;

    function automatic logic [DATA_W-1:0] pack_ctrl(input tmr_cfg_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[CTRL_EN_BIT]                = c.en;
        w[CTRL_IE_BIT]                = c.int_en;
        w[CTRL_MODE_LSB +: 2]         = c.mode;
        w[CTRL_SRC_LSB +: SRC_FW]     = c.src;
        return w;
    endfunction

    function automatic tmr_cfg_t unpack_ctrl(input logic [DATA_W-1:0] w,
                                             input logic [SRC_FW-1:0] smask);
        tmr_cfg_t c;
        c.en     = w[CTRL_EN_BIT];
        c.int_en = w[CTRL_IE_BIT];
        c.mode   = cnt_mode_e'(w[CTRL_MODE_LSB +: 2]);
        c.src    = w[CTRL_SRC_LSB +: SRC_FW] & smask;
        return c;
    endfunction

    function automatic tmr_cfg_t default_cfg(input int idx, input int nsrc);
        tmr_cfg_t c;
        c.en     = 1'b1;
        c.int_en = 1'b0;
        c.mode   = cnt_mode_e'(2'(idx % 4));
        c.src    = SRC_FW'(idx % nsrc);
        return c;
    endfunction

endpackage

// File: rtl/evstat_counter.sv
module evstat_counter
    import evstat_pkg::*;
#(
    parameter int IDX     = 0,
    parameter int NUM_SRC = 8,
    parameter int CNT_W   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  tmr_cfg_t         cfg_wdata,
    input  logic             cnt_we,
    input  logic [CNT_W-1:0] cnt_wdata,
    input  logic [NUM_SRC-1:0] src_now,
    input  logic [NUM_SRC-1:0] src_prev,
    output tmr_cfg_t         cfg_o,
    output logic [CNT_W-1:0] count_o,
    output logic             sat_o
);

    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [SRC_FW-1:0] SRC_MAX = SRC_FW'(NUM_SRC - 1);

    tmr_cfg_t         cfg_q;
    logic [CNT_W-1:0] cnt_q;
    logic             src_ok;
    logic             s_cur;
    logic             s_old;
    logic             hit;

    assign src_ok = (cfg_q.src <= SRC_MAX);
    assign s_cur  = src_ok & src_now[cfg_q.src[SRC_W-1:0]];
    assign s_old  = src_ok & src_prev[cfg_q.src[SRC_W-1:0]];

    always_comb begin
        unique case (cfg_q.mode)
            MODE_HIGH: hit = s_cur;
            MODE_LOW:  hit = src_ok & ~s_cur;
            MODE_RISE: hit = s_cur & ~s_old;
            MODE_FALL: hit = src_ok & ~s_cur & s_old;
            default:   hit = 1'b0;
        endcase
    end

    assign sat_o   = &cnt_q;
    assign count_o = cnt_q;
    assign cfg_o   = cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= default_cfg(IDX, NUM_SRC);
        end else if (cfg_we) begin
            cfg_q <= cfg_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_we) begin
            cnt_q <= cnt_wdata;
        end else if (cfg_q.en && hit && !sat_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R4: a saturated count stays put unless software loads it
    p_sat_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (sat_o && !cnt_we) |=> sat_o);

    // R6: a disabled counter keeps its value
    p_freeze_r6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_q.en && !cnt_we) |=> $stable(count_o));

    // R3: counting advances by at most one per cycle
    p_step_r3: assert property (@(posedge clk) disable iff (rst)
        !cnt_we |=> (count_o == $past(count_o)) || (count_o == $past(count_o) + 1'b1));

    // R5: a load lands exactly
    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        cnt_we |=> count_o == $past(cnt_wdata));

endmodule

// File: rtl/evstat_irq.sv
module evstat_irq #(
    parameter int NUM_TIMERS = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_TIMERS-1:0] sat,
    input  logic [NUM_TIMERS-1:0] ie,
    input  logic                  mask,
    output logic                  irq_o
);

    logic irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= mask & (|(sat & ie));
        end
    end

    assign irq_o = irq_q;

    // R8: with the mask cleared the line is low on the next cycle
    p_irq_mask_r8: assert property (@(posedge clk) disable iff (rst)
        !mask |=> !irq_o);

    // R8: the line only rises after an enabled counter was saturated
    p_irq_cause_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_o) |-> $past(|(sat & ie)));

endmodule

// File: rtl/evstat_bank.sv
module evstat_bank
    import evstat_pkg::*;
#(
    parameter int NUM_TIMERS = 8,
    parameter int NUM_SRC    = 8,
    parameter int CNT_W      = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               bus_en,
    input  logic               bus_we,
    input  logic [2:0]         bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    input  logic [NUM_SRC-1:0] src_in,
    output logic               irq
);

    localparam int IDX_W = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS) : 1;
    localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
    localparam logic [IDX_W-1:0]  SEL_MAX  = IDX_W'(NUM_TIMERS - 1);
    localparam logic [SRC_FW-1:0] SRC_MASK = SRC_FW'((1 << SRC_W) - 1);
    localparam logic [DATA_W-1:0] CAP_WORD =
        (DATA_W'(NUM_SRC - 1) << 8) | DATA_W'(NUM_TIMERS - 1);

    logic [IDX_W-1:0]      sel_q;
    logic                  mask_q;
    logic [NUM_SRC-1:0]    src_q;
    logic                  wr;
    logic                  sel_ok;
    tmr_cfg_t              cfg_new;
    logic [NUM_TIMERS-1:0] cfg_we;
    logic [NUM_TIMERS-1:0] cnt_we;
    logic [NUM_TIMERS-1:0] sat_v;
    logic [NUM_TIMERS-1:0] ie_v;
    tmr_cfg_t              cfg_v [NUM_TIMERS];
    logic [CNT_W-1:0]      cnt_v [NUM_TIMERS];

    assign wr      = bus_en & bus_we;
    assign sel_ok  = (sel_q <= SEL_MAX);
    assign cfg_new = unpack_ctrl(bus_wdata, SRC_MASK);

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q  <= '0;
            mask_q <= 1'b0;
            src_q  <= '0;
        end else begin
            src_q <= src_in;
            if (wr && bus_addr == REG_SEL) begin
                sel_q <= bus_wdata[IDX_W-1:0];
            end
            if (wr && bus_addr == REG_IMASK) begin
                mask_q <= bus_wdata[0];
            end
        end
    end

    for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_tmr
        assign cfg_we[i] = wr && (bus_addr == REG_CTRL)  && (sel_q == IDX_W'(i));
        assign cnt_we[i] = wr && (bus_addr == REG_COUNT) && (sel_q == IDX_W'(i));
        assign ie_v[i]   = cfg_v[i].int_en;

        evstat_counter #(
            .IDX     (i),
            .NUM_SRC (NUM_SRC),
            .CNT_W   (CNT_W)
        ) u_cnt (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (cfg_we[i]),
            .cfg_wdata (cfg_new),
            .cnt_we    (cnt_we[i]),
            .cnt_wdata (bus_wdata[CNT_W-1:0]),
            .src_now   (src_in),
            .src_prev  (src_q),
            .cfg_o     (cfg_v[i]),
            .count_o   (cnt_v[i]),
            .sat_o     (sat_v[i])
        );
    end

    evstat_irq #(
        .NUM_TIMERS (NUM_TIMERS)
    ) u_irq (
        .clk   (clk),
        .rst   (rst),
        .sat   (sat_v),
        .ie    (ie_v),
        .mask  (mask_q),
        .irq_o (irq)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            REG_SEL:   bus_rdata = DATA_W'(sel_q);
            REG_CTRL:  bus_rdata = sel_ok ? pack_ctrl(cfg_v[sel_q]) : '0;
            REG_COUNT: bus_rdata = sel_ok ? DATA_W'(cnt_v[sel_q]) : '0;
            REG_CAP:   bus_rdata = CAP_WORD;
            REG_IMASK: bus_rdata = DATA_W'(mask_q);
            REG_ISTAT: bus_rdata = DATA_W'(irq);
            default:   bus_rdata = '0;
        endcase
    end

    // R1: only one counter can be written at a time
    p_one_target_r1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cnt_we | cfg_we));

    // R3: the edge reference is the source one cycle earlier
    p_prev_r3: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> src_q == $past(src_in));

endmodule

// File: tb/evstat_bank_tb.sv
`timescale 1ns/1ps
module evstat_bank_tb;

    localparam int NT = 8;
    localparam int NS = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [NS-1:0] src_in = '0;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2 clk = ~clk;

    evstat_bank #(.NUM_TIMERS(NT), .NUM_SRC(NS), .CNT_W(32)) u_dut (
        .clk(clk), .rst(rst), .bus_en(bus_en), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_in(src_in), .irq(irq)
    );

    // behavioural reference model
    bit [31:0] m_cnt [NT];
    bit        m_en  [NT];
    bit        m_ie  [NT];
    int        m_mode[NT];
    int        m_src [NT];
    int        m_sel;
    bit        m_mask;
    bit        m_irq;
    bit [NS-1:0] m_prev;

    function automatic bit [31:0] exp_rd(input int a);
        case (a)
            0: return 32'(m_sel);
            1: return 32'(m_en[m_sel]) | (32'(m_ie[m_sel]) << 1) |
                      (32'(m_mode[m_sel]) << 2) | (32'(m_src[m_sel]) << 8);
            2: return m_cnt[m_sel];
            3: return 32'h0000_0707;
            4: return 32'(m_mask);
            5: return 32'(m_irq);
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input int a);
        case (a)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R7";
            4: return "R8";
            5: return "R8";
            default: return "R10";
        endcase
    endfunction

    always @(posedge clk) begin
        bit nxt_irq;
        if (rst) begin
            for (int i = 0; i < NT; i++) begin
                m_cnt[i] = 0; m_en[i] = 1; m_ie[i] = 0;
                m_mode[i] = i % 4; m_src[i] = i % NS;
            end
            m_sel = 0; m_mask = 0; m_irq = 0; m_prev = '0;
        end else begin
            nxt_irq = 0;
            for (int i = 0; i < NT; i++)
                if (m_ie[i] && m_cnt[i] == 32'hFFFF_FFFF) nxt_irq = m_mask;
            for (int i = 0; i < NT; i++) begin
                bit s, p, ev;
                s = src_in[m_src[i]];
                p = m_prev[m_src[i]];
                case (m_mode[i])
                    0: ev = s;
                    1: ev = !s;
                    2: ev = s && !p;
                    default: ev = !s && p;
                endcase
                if (m_en[i] && ev && m_cnt[i] != 32'hFFFF_FFFF) m_cnt[i] = m_cnt[i] + 1;
            end
            if (bus_en && bus_we) begin
                case (bus_addr)
                    3'd0: m_sel = int'(bus_wdata[2:0]);
                    3'd1: begin
                        m_en[m_sel] = bus_wdata[0];
                        m_ie[m_sel] = bus_wdata[1];
                        m_mode[m_sel] = int'(bus_wdata[3:2]);
                        m_src[m_sel] = int'(bus_wdata[10:8]);
                    end
                    3'd2: m_cnt[m_sel] = bus_wdata;
                    3'd4: m_mask = bus_wdata[0];
                    default: ;
                endcase
            end
            m_prev = src_in;
            m_irq = nxt_irq;
        end
        #1;
        if (!rst) begin
            checks++;
            if (irq !== m_irq) begin
                fails++;
                $display("FAIL R8: irq=%0b expected %0b at %0t", irq, m_irq, $time);
            end
            if (bus_en && !bus_we) begin
                checks++;
                if (bus_rdata !== exp_rd(int'(bus_addr))) begin
                    fails++;
                    $display("FAIL %s: rdata[%0d]=%h expected %h", tag_of(int'(bus_addr)),
                             bus_addr, bus_rdata, exp_rd(int'(bus_addr)));
                end
            end
        end
    end

    task automatic wr(input int a, input bit [31:0] d);
        bus_en = 1; bus_we = 1; bus_addr = 3'(a); bus_wdata = d;
        @(negedge clk);
        bus_en = 0; bus_we = 0;
    endtask

    task automatic rd_exp(input int a, input bit [31:0] e, input string tag);
        bus_en = 1; bus_we = 0; bus_addr = 3'(a);
        @(posedge clk); #1;
        checks++;
        if (bus_rdata !== e) begin
            fails++;
            $display("FAIL %s: rdata[%0d]=%h expected %h", tag, a, bus_rdata, e);
        end
        @(negedge clk);
        bus_en = 0;
    endtask

    task automatic irq_exp(input bit e, input string tag);
        @(posedge clk); #1;
        checks++;
        if (irq !== e) begin
            fails++;
            $display("FAIL %s: irq=%0b expected %0b", tag, irq, e);
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse0(input int width);
        src_in[0] = 1; idle(width);
        src_in[0] = 0; idle(1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R9: reset state
        rd_exp(0, 32'h0, "R9");
        rd_exp(1, 32'h001, "R9");
        rd_exp(2, 32'h0, "R9");
        rd_exp(4, 32'h0, "R9");
        rd_exp(3, 32'h0707, "R7");
        wr(0, 5);
        rd_exp(1, 32'h505, "R9");
        // stop and clear all counters (R5)
        for (int i = 0; i < NT; i++) begin
            wr(0, i);
            wr(1, ((i % 4) << 2) | (i << 8));
            wr(2, 0);
        end
        rd_exp(2, 32'h0, "R5");
        wr(0, 0);
        // R3: rising edges
        wr(1, 32'h009); pulse0(1); pulse0(1); pulse0(1); wr(1, 32'h008);
        rd_exp(2, 3, "R3");
        // R3: falling edges
        wr(2, 0); wr(1, 32'h00D); pulse0(1); pulse0(1); pulse0(1); wr(1, 32'h00C);
        rd_exp(2, 3, "R3");
        // R3: high level, three pulses of two cycles
        wr(2, 0); wr(1, 32'h001); pulse0(2); pulse0(2); pulse0(2); wr(1, 32'h000);
        rd_exp(2, 6, "R3");
        // R3: low level while source held high
        src_in[0] = 1;
        wr(2, 0); wr(1, 32'h005); idle(4); wr(1, 32'h004);
        rd_exp(2, 0, "R3");
        src_in[0] = 0;
        // R4: saturation
        wr(2, 32'hFFFF_FFFE); wr(1, 32'h003);
        src_in[0] = 1; idle(3);
        rd_exp(2, 32'hFFFF_FFFF, "R4");
        idle(2);
        rd_exp(2, 32'hFFFF_FFFF, "R4");
        // R8: interrupt masking and clearing
        irq_exp(0, "R8");
        wr(4, 1); idle(1);
        irq_exp(1, "R8");
        rd_exp(5, 1, "R8");
        wr(4, 0); idle(1);
        irq_exp(0, "R8");
        wr(4, 1); idle(2);
        src_in[0] = 0;
        wr(2, 0); idle(1);
        irq_exp(0, "R8");
        wr(1, 32'h000); wr(4, 0);
        // R6: freeze and resume
        src_in[0] = 1;
        wr(2, 5); idle(3);
        rd_exp(2, 5, "R6");
        wr(1, 32'h001); idle(2); wr(1, 32'h000);
        rd_exp(2, 8, "R6");
        src_in[0] = 0;
        // R1: isolation between counters and index masking
        wr(0, 3); wr(2, 32'h55);
        wr(0, 4); rd_exp(2, 0, "R1");
        wr(0, 32'hB); rd_exp(0, 3, "R1");
        rd_exp(2, 32'h55, "R1");
        // R2: control layout readback with upper junk bits
        wr(1, 32'hFFFF_F60E);
        rd_exp(1, 32'h0000_060E, "R2");
        // R10: unmapped and read-only offsets
        wr(3, 0); wr(5, 1); wr(6, 32'hFFFF_FFFF); wr(7, 32'h1234);
        rd_exp(3, 32'h0707, "R10");
        rd_exp(6, 0, "R10");
        rd_exp(7, 0, "R10");
        rd_exp(4, 0, "R10");
        // model-checked random traffic, with a reset in the middle (R9)
        for (int c = 0; c < 4000; c++) begin
            int op;
            src_in = NS'($urandom);
            op = int'($urandom_range(0, 15));
            if (c == 2000) begin
                rst = 1; idle(2); rst = 0;
            end
            if (op < 4) begin
                bus_en = 1; bus_we = 0; bus_addr = 3'($urandom);
                @(negedge clk); bus_en = 0;
            end else if (op == 4) wr(0, $urandom);
            else if (op == 5) wr(1, $urandom);
            else if (op == 6) wr(2, 32'hFFFF_FFF0 | 32'($urandom_range(0, 15)));
            else if (op == 7) wr(2, 0);
            else if (op == 8) wr(4, $urandom);
            else if (op == 9) wr(int'($urandom_range(3, 7)), $urandom);
            else idle(1);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: running=1 expected 0");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule